// File: doc/BRIEF.md
# Sound Control Register Bank

This block holds the byte-wide control registers of a four-channel sound unit and sits on a simple CPU bus. The bus has an 8-bit address offset, a write strobe with write data, and a read strobe. Read data comes back registered one clock later. The block stores a control byte for each channel, the master volume and panning bytes, and a master enable/status byte. It also holds a 16-byte waveform table. Its contents go out to the sound channels as flat vectors.

Reads OR a fixed mask of unreadable bits into each stored byte. The channel registers are gated by the master enable. While the unit is off, a write to a channel, volume or panning register is dropped: it is not passed on to the channel logic and the stored byte stays zero. Clearing the master enable zeroes all of those bytes at the same clock edge. Writes to the status register are always passed on, so the unit can be turned back on. The waveform table ignores the enable.

Each accepted control write is passed to the channel logic in the same cycle, on a pulse together with its offset and data. The generators, envelopes and length counters live outside this block. They return four channel-active bits, which this block shows in the status byte.

Top module: `snd_reg_bank`

Register offsets and read masks:

| Offset | Register | Read mask |
|---|---|---|
| 0x00 | ch1 sweep | 0x80 |
| 0x01 | ch1 duty/length | 0x3F |
| 0x02 | ch1 envelope | 0x00 |
| 0x03 | ch1 frequency low | 0xFF |
| 0x04 | ch1 frequency high/trigger | 0xBF |
| 0x06 | ch2 duty/length | 0x3F |
| 0x07 | ch2 envelope | 0x00 |
| 0x08 | ch2 frequency low | 0xFF |
| 0x09 | ch2 frequency high/trigger | 0xBF |
| 0x0A | ch3 enable | 0x7F |
| 0x0B | ch3 length | 0xFF |
| 0x0C | ch3 level | 0x9F |
| 0x0D | ch3 frequency low | 0xFF |
| 0x0E | ch3 frequency high/trigger | 0xBF |
| 0x10 | ch4 length | 0xFF |
| 0x11 | ch4 envelope | 0x00 |
| 0x12 | ch4 polynomial | 0x00 |
| 0x13 | ch4 control/trigger | 0xBF |
| 0x14 | master volume | 0x00 |
| 0x15 | panning | 0x00 |
| 0x16 | master status | 0x70 |
| 0x20-0x2F | waveform table | 0x00 |

## Requirements
- R1: After reset, `snd_enable` is 0, `bus_rvalid` is 0, and every control byte and waveform byte is zero.
- R2: A read strobe in cycle N gives `bus_rvalid`=1 in cycle N+1, with `bus_rdata` equal to the stored byte ORed with its read mask from the table above. The value is sampled before any write in cycle N. Without a read strobe, `bus_rvalid` is 0.
- R3: The frequency-low registers at 0x03, 0x08 and 0x0D always read 0xFF.
- R4: A read of an unmapped offset returns 0xFF. The unmapped offsets are 0x05, 0x0F, 0x17-0x1F and 0x30-0xFF.
- R5: While `snd_enable` is 0, a write to 0x00-0x15 is dropped. `fwd_wr` stays 0 and the stored byte stays zero.
- R6: A write to 0x16 stores only bus bit 7 as the master enable. A read of 0x16 returns {enable, 3'b111, chan_active[3:0]}, where `chan_active` is taken in the read-strobe cycle.
- R7: A write to 0x16 always raises `fwd_wr` in the same cycle, whatever the enable state.
- R8: A write to 0x16 with bit 7 clear zeroes every byte at 0x00-0x15 at that clock edge.
- R9: A write to 0x20-0x2F stores its byte at index (offset - 0x20), whatever the enable state. It shows on `wave_o[8*index +: 8]` and reads back unmasked.
- R10: While enabled, a write to a mapped offset in 0x00-0x15 raises `fwd_wr` in the same cycle, with `fwd_addr`/`fwd_data` equal to the bus offset and data. The byte appears on `chan_regs_o[8*offset +: 8]` after that edge. Writes to unmapped offsets are not stored and not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| chan_active | input | 4 | Channel-active status from the channels |
| snd_enable | output | 1 | Master enable |
| chan_regs_o | output | 176 | Control bytes at offsets 0x00-0x15, byte k at bits 8k+7:8k |
| wave_o | output | 128 | Waveform table, byte i at bits 8i+7:8i |
| fwd_wr | output | 1 | Accepted control/status write pulse to the channel logic |
| fwd_addr | output | 8 | Offset of the forwarded write |
| fwd_data | output | 8 | Data of the forwarded write |

## Verification
A wrong enable bit shows up on the forward pulse in the same cycle as the next gated write. It also shows up on `chan_regs_o` one edge later, because a byte that should be dropped is stored instead. A corrupt stored byte or a wrong mask shows on `bus_rdata` one cycle after the read strobe. The exported vectors expose every stored bit after every edge. The reference model therefore compares all of them on every clock, so a fault shows within one cycle of the write that causes it.

// File: rtl/snd_regs_pkg.sv
package snd_regs_pkg;
  localparam int          CTRL_BYTES = 22;
  localparam int          NUM_CH     = 4;
  localparam logic [7:0]  STATUS_OFS = 8'h16;
  localparam logic [7:0]  FILL_BYTE  = 8'hFF;
  localparam logic [7:0]  STATUS_FIX = 8'h70;

  function automatic logic ctrl_mapped(input logic [7:0] a);
    return (a < 8'(CTRL_BYTES)) && (a != 8'h05) && (a != 8'h0F);
  endfunction

  function automatic logic [7:0] ctrl_mask(input logic [7:0] a);
    logic [7:0] m;
    case (a)
      8'h00:                      m = 8'h80;
      8'h01, 8'h06:               m = 8'h3F;
      8'h03, 8'h08, 8'h0D:        m = 8'hFF;
      8'h04, 8'h09, 8'h0E, 8'h13: m = 8'hBF;
      8'h0A:                      m = 8'h7F;
      8'h0B, 8'h10:               m = 8'hFF;
      8'h0C:                      m = 8'h9F;
      default:                    m = 8'h00;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/snd_master_ctl.sv
module snd_master_ctl
  import snd_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic       enable,
  output logic       clear
);
  logic hit;
  assign hit   = wr_en && (addr == STATUS_OFS);
  assign clear = hit && !wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n)   enable <= 1'b0;
    else if (hit) enable <= wdata[7];
  end
endmodule

// File: rtl/snd_ctrl_file.sv
module snd_ctrl_file
  import snd_regs_pkg::*;
#(
  parameter int BYTES = CTRL_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         addr,
  input  logic [7:0]         wdata,
  input  logic               enable,
  input  logic               clear,
  output logic [BYTES*8-1:0] regs_flat
);
  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    localparam logic MAPPED = ctrl_mapped(8'(i));
    if (MAPPED) begin : g_live
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (clear)
          q <= '0;
        else if (wr_en && enable && (addr == 8'(i)))
          q <= wdata;
      end
      assign regs_flat[i*8 +: 8] = q;
    end else begin : g_hole
      assign regs_flat[i*8 +: 8] = '0;
    end
  end
endmodule

// File: rtl/snd_wave_table.sv
module snd_wave_table #(
  parameter int         BYTES = 16,
  parameter logic [7:0] BASE  = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         addr,
  input  logic [7:0]         wdata,
  output logic [BYTES*8-1:0] wave_flat
);
  for (genvar i = 0; i < BYTES; i++) begin : g_cell
    localparam logic [7:0] OFS = BASE + 8'(i);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                       q <= '0;
      else if (wr_en && (addr == OFS))  q <= wdata;
    end
    assign wave_flat[i*8 +: 8] = q;
  end
endmodule

// File: rtl/snd_read_port.sv
module snd_read_port
  import snd_regs_pkg::*;
#(
  parameter int         WAVE_BYTES = 16,
  parameter logic [7:0] WAVE_BASE  = 8'h20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic [7:0]              addr,
  input  logic [CTRL_BYTES*8-1:0] ctrl_flat,
  input  logic [WAVE_BYTES*8-1:0] wave_flat,
  input  logic                    enable,
  input  logic [NUM_CH-1:0]       active,
  output logic [7:0]              rdata,
  output logic                    rvalid
);
  logic [7:0] next_byte;

  always_comb begin
    next_byte = FILL_BYTE;
    if (addr == STATUS_OFS) begin
      next_byte = STATUS_FIX | {enable, 7'b0} | 8'(active);
    end else begin
      for (int i = 0; i < CTRL_BYTES; i++)
        if (ctrl_mapped(8'(i)) && (addr == 8'(i)))
          next_byte = ctrl_flat[i*8 +: 8] | ctrl_mask(8'(i));
      for (int j = 0; j < WAVE_BYTES; j++)
        if (addr == WAVE_BASE + 8'(j))
          next_byte = wave_flat[j*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= next_byte;
    end
  end
endmodule

// File: rtl/snd_reg_bank.sv
module snd_reg_bank
  import snd_regs_pkg::*;
#(
  parameter int         WAVE_BYTES = 16,
  parameter logic [7:0] WAVE_BASE  = 8'h20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [7:0]                    bus_addr,
  input  logic                          bus_wr,
  input  logic [7:0]                    bus_wdata,
  input  logic                          bus_rd,
  output logic [7:0]                    bus_rdata,
  output logic                          bus_rvalid,
  input  logic [NUM_CH-1:0]             chan_active,
  output logic                          snd_enable,
  output logic [CTRL_BYTES*8-1:0]       chan_regs_o,
  output logic [WAVE_BYTES*8-1:0]       wave_o,
  output logic                          fwd_wr,
  output logic [7:0]                    fwd_addr,
  output logic [7:0]                    fwd_data
);
  logic clear_all;

  snd_master_ctl u_master (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .enable(snd_enable), .clear(clear_all)
  );

  snd_ctrl_file #(.BYTES(CTRL_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .enable(snd_enable), .clear(clear_all),
    .regs_flat(chan_regs_o)
  );

  snd_wave_table #(.BYTES(WAVE_BYTES), .BASE(WAVE_BASE)) u_wave (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .wave_flat(wave_o)
  );

  snd_read_port #(.WAVE_BYTES(WAVE_BYTES), .WAVE_BASE(WAVE_BASE)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .addr(bus_addr),
    .ctrl_flat(chan_regs_o), .wave_flat(wave_o), .enable(snd_enable),
    .active(chan_active), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  assign fwd_wr   = bus_wr && ((bus_addr == STATUS_OFS) ||
                               (snd_enable && ctrl_mapped(bus_addr)));
  assign fwd_addr = bus_addr;
  assign fwd_data = bus_wdata;
endmodule

// File: rtl/snd_reg_bank_chk.sv
module snd_reg_bank_chk
  import snd_regs_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic [7:0]              bus_addr,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [7:0]              bus_rdata,
  input logic                    bus_rvalid,
  input logic                    snd_enable,
  input logic [CTRL_BYTES*8-1:0] chan_regs_o,
  input logic                    fwd_wr
);
  // R5
  gated_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snd_enable && bus_wr && bus_addr < STATUS_OFS) |-> !fwd_wr);
  // R7
  status_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == STATUS_OFS) |-> fwd_wr);
  // R8
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_enable |-> (chan_regs_o == '0));
  // R2
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  // R2
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  // R3
  wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == 8'h03 || bus_addr == 8'h08 || bus_addr == 8'h0D))
      |=> (bus_rdata == 8'hFF));
  // R4
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= 8'h30) |=> (bus_rdata == 8'hFF));
  // R6
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STATUS_OFS)
      |=> (bus_rdata[6:4] == 3'b111 && bus_rdata[7] == $past(snd_enable)));
endmodule

bind snd_reg_bank snd_reg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .snd_enable(snd_enable), .chan_regs_o(chan_regs_o), .fwd_wr(fwd_wr)
);

// File: tb/snd_reg_bank_tb.sv
module snd_reg_bank_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_rdata;
  logic         bus_rvalid;
  logic [3:0]   chan_active = '0;
  logic         snd_enable;
  logic [175:0] chan_regs_o;
  logic [127:0] wave_o;
  logic         fwd_wr;
  logic [7:0]   fwd_addr;
  logic [7:0]   fwd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] m_ctrl [22];
  logic [7:0] m_wave [16];
  bit         m_en;

  always #5 clk = ~clk;

  snd_reg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .chan_active(chan_active),
    .snd_enable(snd_enable), .chan_regs_o(chan_regs_o), .wave_o(wave_o),
    .fwd_wr(fwd_wr), .fwd_addr(fwd_addr), .fwd_data(fwd_data)
  );

  task automatic chk(input string tag, input logic [175:0] act, input logic [175:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [7:0] a);
    return (a < 8'h16) && a != 8'h05 && a != 8'h0F;
  endfunction

  function automatic logic [7:0] mask_of(input logic [7:0] a);
    case (a)
      8'h00: return 8'h80;
      8'h01, 8'h06: return 8'h3F;
      8'h03, 8'h08, 8'h0D, 8'h0B, 8'h10: return 8'hFF;
      8'h04, 8'h09, 8'h0E, 8'h13: return 8'hBF;
      8'h0A: return 8'h7F;
      8'h0C: return 8'h9F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [3:0] act);
    if (a == 8'h16) return {m_en, 3'b111, act};
    if (mapped(a)) return m_ctrl[a] | mask_of(a);
    if (a >= 8'h20 && a < 8'h30) return m_wave[a - 8'h20];
    return 8'hFF;
  endfunction

  function automatic logic [175:0] pack_ctrl();
    logic [175:0] v = '0;
    for (int i = 0; i < 22; i++) v[i*8 +: 8] = m_ctrl[i];
    return v;
  endfunction

  function automatic logic [127:0] pack_wave();
    logic [127:0] v = '0;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = m_wave[i];
    return v;
  endfunction

  task automatic step(input string tag, input bit wr, input bit rd,
                      input logic [7:0] a, input logic [7:0] d, input logic [3:0] act);
    logic [7:0] er;
    bit ef;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; chan_active = act;
    #1;
    ef = wr && (a == 8'h16 || (m_en && mapped(a)));
    chk({tag, " fwd_wr"}, 176'(fwd_wr), 176'(ef));
    if (ef) chk({tag, " fwd addr/data"}, 176'({fwd_addr, fwd_data}), 176'({a, d}));
    er = exp_read(a, act);
    if (wr) begin
      if (a == 8'h16) begin
        m_en = d[7];
        if (!d[7]) for (int i = 0; i < 22; i++) m_ctrl[i] = '0;
      end else if (mapped(a)) begin
        if (m_en) m_ctrl[a] = d;
      end else if (a >= 8'h20 && a < 8'h30) begin
        m_wave[a - 8'h20] = d;
      end
    end
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk({tag, " rvalid"}, 176'(bus_rvalid), 176'(rd));
    if (rd) chk({tag, " rdata"}, 176'(bus_rdata), 176'(er));
    chk({tag, " enable"}, 176'(snd_enable), 176'(m_en));
    chk({tag, " chan_regs"}, chan_regs_o, pack_ctrl());
    chk({tag, " wave"}, 176'(wave_o), 176'(pack_wave()));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_en = 0;
    for (int i = 0; i < 22; i++) m_ctrl[i] = '0;
    for (int i = 0; i < 16; i++) m_wave[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 enable", 176'(snd_enable), 176'(0));
    chk("R1 rvalid", 176'(bus_rvalid), 176'(0));
    chk("R1 chan_regs", chan_regs_o, '0);
    chk("R1 wave", 176'(wave_o), '0);
    // R5 gated write while off
    step("R5", 1, 0, 8'h02, 8'h77, 4'h0);
    step("R5", 0, 1, 8'h02, 8'h00, 4'h0);
    // R7 enable through status while off
    step("R7", 1, 0, 8'h16, 8'h80, 4'h0);
    // R10 channel write forwarded and stored, R2 masked read
    step("R10", 1, 0, 8'h01, 8'hAB, 4'h0);
    step("R2", 0, 1, 8'h01, 8'h00, 4'h0);
    step("R10", 1, 0, 8'h0C, 8'h20, 4'h0);
    step("R2", 0, 1, 8'h0C, 8'h00, 4'h0);
    // R3 write-only frequency low
    step("R3", 1, 0, 8'h03, 8'h12, 4'h0);
    step("R3", 0, 1, 8'h03, 8'h00, 4'h0);
    step("R3", 0, 1, 8'h0D, 8'h00, 4'h0);
    // R4 unmapped offsets
    step("R4", 1, 0, 8'h05, 8'h33, 4'h0);
    step("R4", 0, 1, 8'h05, 8'h00, 4'h0);
    step("R4", 0, 1, 8'h1A, 8'h00, 4'h0);
    step("R4", 0, 1, 8'hC3, 8'h00, 4'h0);
    // R6 status write keeps only bit 7; read mixes channel status
    step("R6", 1, 0, 8'h16, 8'hFF, 4'h0);
    step("R6", 0, 1, 8'h16, 8'h00, 4'hA);
    // R9 wave table edges
    step("R9", 1, 0, 8'h20, 8'hC1, 4'h0);
    step("R9", 1, 0, 8'h2F, 8'h5A, 4'h0);
    step("R9", 0, 1, 8'h2F, 8'h00, 4'h0);
    // R2 read sees pre-write value when write in same cycle
    step("R2", 1, 1, 8'h14, 8'h66, 4'h0);
    step("R2", 0, 1, 8'h14, 8'h00, 4'h0);
    // R8 disabling zeroes control bytes
    step("R8", 1, 0, 8'h16, 8'h7F, 4'h0);
    step("R8", 0, 1, 8'h16, 8'h00, 4'h5);
    step("R5", 1, 1, 8'h15, 8'h99, 4'h0);
    step("R5", 0, 1, 8'h15, 8'h00, 4'h0);
    step("R9", 1, 0, 8'h27, 8'h3C, 4'h0);
    step("R9", 0, 1, 8'h27, 8'h00, 4'h0);
    step("R7", 1, 0, 8'h16, 8'h80, 4'h3);
    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      logic [7:0] d;
      a = 8'($urandom % 56);
      d = 8'($urandom);
      if (a == 8'h16) d = ($urandom % 4 != 0) ? 8'h80 : 8'h00;
      step("R10", 1'($urandom), 1'($urandom), a, d, 4'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule